// File: doc/BRIEF.md
# Lockable Two-Bank Pin Function Controller

This block is the register-mapped control point for a large set of package pins. Software writes a configuration word per pin into a first bank. That word selects a direct function, a pull bias and a drive strength. One reserved code in the first bank hands the pin to a second bank, which holds a wider extended function number. The second bank also holds two source selects for the management-data (MDIO) channels. The block resolves both banks into one function code per pin, plus pull and drive outputs, which the pad ring and peripheral muxes consume.

Both banks are write-protected after reset. A bank opens or closes only when software writes its protect register with a key: the protect register's own full bus address, where bit 0 chooses open (1) or closed (0). Any other value written there is discarded. A closed bank drops writes to its pin words and MDIO words, but reads still return the stored values.

Top module: `pin_mux_ctrl`

## Requirements
- R1: After reset both banks are locked (protect reads have bit 0 = 0), every pin has first-bank function 0, pull 0 and drive 2 (first-bank word reads 0x800), every extended number is 0, and both MDIO selects are 0.
- R2: Writing a bank's protect register with its own bus address (BASE_ADDR + bank*0x1000 + 0x400) with bit 0 set unlocks that bank, and the same address with bit 0 clear locks it. A protect read returns that address with bit 0 = 1 when unlocked. The two banks lock independently.
- R3: A protect write whose bits 31:1 differ from that register's own address leaves the lock state unchanged.
- R4: While a bank is locked, writes to its pin words and MDIO words change no stored value and no output, and reads return the stored value.
- R5: The first-bank word of pin p sits at byte offset 4*p of bank 0. Bits 3:0 are the function, bits 9:8 the pull (0 none, 1 up, 3 down), and bits 11:10 the drive (0..3 = 4, 6, 8, 12 mA). Other bits read 0. Pull and drive drive the pin's outputs directly.
- R6: The pin's resolved function is the first-bank value when it is 0..9, 0 (high-impedance) when it is 10..14, and 16 plus the extended number when it is 0xF.
- R7: The extended word of pin p sits at byte offset 4*p of bank 1 (bank offset 0x1000). Only bits 5:0 are stored (0..61 are meaningful), and other bits read 0.
- R8: MDIO selects 0 and 1 sit at bank-1 byte offsets 0x404 and 0x408. Each stores bits 2:0 (0 = high-impedance, 1..7 = a source) and drives its own output.
- R9: A read request returns data with valid one cycle later. Words at offsets outside the mapped registers (including pin index NUM_PINS and beyond) and addresses outside the 8 KiB window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Full byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| pin_func_o | output | NUM_PINS*7 | Resolved function code per pin, pin p at bits 7p+6:7p |
| pin_pull_o | output | NUM_PINS*2 | Pull bias per pin |
| pin_drive_o | output | NUM_PINS*2 | Drive strength per pin |
| mdio0_sel_o | output | 3 | MDIO channel 0 source select |
| mdio1_sel_o | output | 3 | MDIO channel 1 source select |

## Verification
The write gate and the per-pin resolver meet on the same clock edge. An extended-number write into bank 1 changes the pin's function output in that same cycle, but only if the first-bank word already holds the hand-off code. The bench provokes this by writing the extended number of one pin whose first-bank code is 0xF and of another whose code is 0. It then checks that only the first output moves. It also places unlock and lock writes right before gated writes and checks that the lock state reached on one edge governs the access on the next.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;

  localparam int L1F_W         = 4;
  localparam int L2_W          = 6;
  localparam int FUNC_W        = 7;
  localparam int PULL_W        = 2;
  localparam int DRV_W         = 2;
  localparam int MDIO_W        = 3;
  localparam int L1_DIRECT_MAX = 9;
  localparam int L2_BASE       = 16;
  localparam logic [L1F_W-1:0] L1_HANDOFF = 4'hF;
  localparam logic [DRV_W-1:0] DRV_RESET  = 2'd2;
  localparam logic [31:0]      PROT_OFS   = 32'h0000_0400;

  typedef struct packed {
    logic [DRV_W-1:0]  drive;
    logic [PULL_W-1:0] pull;
    logic [L1F_W-1:0]  func;
  } l1_cfg_t;

  // Lay a first-bank configuration out as a bus word.
  function automatic logic [31:0] l1_to_word(l1_cfg_t c);
    return {20'b0, c.drive, c.pull, 4'b0, c.func};
  endfunction

  // Pick the first-bank fields out of a bus word.
  function automatic l1_cfg_t word_to_l1(logic [31:0] w);
    l1_cfg_t c;
    c.drive = w[11:10];
    c.pull  = w[9:8];
    c.func  = w[3:0];
    return c;
  endfunction

  // Combine the two levels into one function code.
  function automatic logic [FUNC_W-1:0] resolve_func(logic [L1F_W-1:0] l1f,
                                                     logic [L2_W-1:0] l2n);
    if (l1f == L1_HANDOFF)
      return FUNC_W'(L2_BASE) + {1'b0, l2n};
    else if (l1f <= L1F_W'(L1_DIRECT_MAX))
      return {3'b0, l1f};
    else
      return '0;
  endfunction

  // Bus address of a bank's protect register.
  function automatic logic [31:0] prot_addr(logic [31:0] base, int bank_bit, int bank);
    return base + (32'(bank) << bank_bit) + PROT_OFS;
  endfunction

endpackage

// File: rtl/pin_mux_decode.sv
module pin_mux_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h4006_6000,
  parameter int          NUM_PINS  = 170,
  parameter int          BANK_BIT  = 12,
  parameter int          IDX_W     = BANK_BIT - 2
) (
  input  logic [31:0]      addr_i,
  output logic             in_win_o,
  output logic             bank_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_cfg_o,
  output logic             hit_prot_o,
  output logic [1:0]       hit_mdio_o
);
  localparam logic [IDX_W-1:0] PINS_W   = IDX_W'(NUM_PINS);
  localparam logic [IDX_W-1:0] PROT_IDX = IDX_W'(32'h400 >> 2);

  always_comb begin
    in_win_o   = (addr_i[31:BANK_BIT+1] == BASE_ADDR[31:BANK_BIT+1]) &&
                 (addr_i[1:0] == 2'b00);
    bank_o     = addr_i[BANK_BIT];
    idx_o      = addr_i[BANK_BIT-1:2];
    hit_cfg_o  = in_win_o && (idx_o < PINS_W);
    hit_prot_o = in_win_o && (idx_o == PROT_IDX);
    hit_mdio_o[0] = in_win_o && bank_o && (idx_o == PROT_IDX + IDX_W'(1));
    hit_mdio_o[1] = in_win_o && bank_o && (idx_o == PROT_IDX + IDX_W'(2));
  end
endmodule

// File: rtl/pin_mux_bank_lock.sv
module pin_mux_bank_lock #(
  parameter logic [31:0] PROT_ADDR = 32'h4006_6400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prot_wr_i,
  input  logic [31:0] wdata_i,
  output logic        key_hit_o,
  output logic        unlocked_o
);
  assign key_hit_o = prot_wr_i && (wdata_i[31:1] == PROT_ADDR[31:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked_o <= 1'b0;
    else if (key_hit_o) unlocked_o <= wdata_i[0];
  end
endmodule

// File: rtl/pin_mux_pin_cell.sv
module pin_mux_pin_cell
  import pin_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1_we_i,
  input  l1_cfg_t           l1_wr_i,
  input  logic              l2_we_i,
  input  logic [L2_W-1:0]   l2_wr_i,
  output l1_cfg_t           l1_q_o,
  output logic [L2_W-1:0]   l2_q_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [PULL_W-1:0] pull_o,
  output logic [DRV_W-1:0]  drive_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q_o <= '{drive: DRV_RESET, pull: '0, func: '0};
      l2_q_o <= '0;
    end else begin
      if (l1_we_i) l1_q_o <= l1_wr_i;
      if (l2_we_i) l2_q_o <= l2_wr_i;
    end
  end

  assign func_o  = resolve_func(l1_q_o.func, l2_q_o);
  assign pull_o  = l1_q_o.pull;
  assign drive_o = l1_q_o.drive;
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
  import pin_mux_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4006_6000,
  parameter int          NUM_PINS  = 170,
  parameter int          BANK_BIT  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [31:0]                bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic [31:0]                bus_rdata_o,
  output logic                       bus_rvalid_o,
  output logic [NUM_PINS*FUNC_W-1:0] pin_func_o,
  output logic [NUM_PINS*PULL_W-1:0] pin_pull_o,
  output logic [NUM_PINS*DRV_W-1:0]  pin_drive_o,
  output logic [MDIO_W-1:0]          mdio0_sel_o,
  output logic [MDIO_W-1:0]          mdio1_sel_o
);
  localparam int IDX_W = BANK_BIT - 2;

  // Named internal events, used by the checker.
  logic             in_win, bank, hit_cfg, hit_prot;
  logic [1:0]       hit_mdio;
  logic [IDX_W-1:0] idx;
  logic             wr_fire, rd_fire;
  logic [1:0]       key_hit, bank_unlocked;
  logic             wr_l1, wr_l2;
  logic [1:0]       wr_mdio;
  logic [31:0]      prot_word [2];

  l1_cfg_t          l1_q [NUM_PINS];
  logic [L2_W-1:0]  l2_q [NUM_PINS];
  logic [MDIO_W-1:0] mdio_q [2];

  pin_mux_decode #(
    .BASE_ADDR(BASE_ADDR), .NUM_PINS(NUM_PINS), .BANK_BIT(BANK_BIT), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(bus_addr_i), .in_win_o(in_win), .bank_o(bank), .idx_o(idx),
    .hit_cfg_o(hit_cfg), .hit_prot_o(hit_prot), .hit_mdio_o(hit_mdio)
  );

  assign wr_fire = bus_req_i &&  bus_we_i;
  assign rd_fire = bus_req_i && !bus_we_i;

  // One protect register and lock per bank.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [31:0] PADDR = prot_addr(BASE_ADDR, BANK_BIT, b);
    pin_mux_bank_lock #(.PROT_ADDR(PADDR)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .prot_wr_i(wr_fire && hit_prot && (bank == 1'(b))),
      .wdata_i(bus_wdata_i),
      .key_hit_o(key_hit[b]),
      .unlocked_o(bank_unlocked[b])
    );
    assign prot_word[b] = {PADDR[31:1], bank_unlocked[b]};
  end

  assign wr_l1      = wr_fire && hit_cfg && !bank && bank_unlocked[0];
  assign wr_l2      = wr_fire && hit_cfg &&  bank && bank_unlocked[1];
  assign wr_mdio[0] = wr_fire && hit_mdio[0] && bank_unlocked[1];
  assign wr_mdio[1] = wr_fire && hit_mdio[1] && bank_unlocked[1];

  // Per-pin storage and resolution.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel = (idx == IDX_W'(p));
    pin_mux_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l1_we_i(wr_l1 && sel), .l1_wr_i(word_to_l1(bus_wdata_i)),
      .l2_we_i(wr_l2 && sel), .l2_wr_i(bus_wdata_i[L2_W-1:0]),
      .l1_q_o(l1_q[p]), .l2_q_o(l2_q[p]),
      .func_o(pin_func_o[p*FUNC_W +: FUNC_W]),
      .pull_o(pin_pull_o[p*PULL_W +: PULL_W]),
      .drive_o(pin_drive_o[p*DRV_W +: DRV_W])
    );
  end

  // MDIO source selects live in bank 1.
  for (genvar m = 0; m < 2; m++) begin : g_mdio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mdio_q[m] <= '0;
      else if (wr_mdio[m]) mdio_q[m] <= bus_wdata_i[MDIO_W-1:0];
    end
  end
  assign mdio0_sel_o = mdio_q[0];
  assign mdio1_sel_o = mdio_q[1];

  // Read path: one registered stage.
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit_cfg) begin
      if (!bank) rd_word = l1_to_word(l1_q[idx]);
      else       rd_word = {{(32-L2_W){1'b0}}, l2_q[idx]};
    end else if (hit_prot) begin
      rd_word = prot_word[bank];
    end else if (hit_mdio[0]) begin
      rd_word = {{(32-MDIO_W){1'b0}}, mdio_q[0]};
    end else if (hit_mdio[1]) begin
      rd_word = {{(32-MDIO_W){1'b0}}, mdio_q[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= rd_fire;
      bus_rdata_o  <= rd_fire ? rd_word : '0;
    end
  end
endmodule

// File: rtl/pin_mux_ctrl_chk.sv
module pin_mux_ctrl_chk
  import pin_mux_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic                bus_rvalid_o,
  input logic [1:0]          key_hit,
  input logic [1:0]          bank_unlocked,
  input logic [FUNC_W-1:0]   pin0_func,
  input logic [PULL_W-1:0]   pin0_pull,
  input logic [DRV_W-1:0]    pin0_drive,
  input logic [MDIO_W-1:0]   mdio0_sel_o,
  input logic [MDIO_W-1:0]   mdio1_sel_o
);
  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o);

  a_r3_lock0_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_unlocked[0] != $past(bank_unlocked[0])) |-> $past(key_hit[0]));

  a_r3_lock1_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_unlocked[1] != $past(bank_unlocked[1])) |-> $past(key_hit[1]));

  a_r4_l1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_unlocked[0] |=> ($stable(pin0_pull) && $stable(pin0_drive)));

  a_r4_mdio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_unlocked[1] |=> ($stable(mdio0_sel_o) && $stable(mdio1_sel_o)));

  a_r6_gap_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !((pin0_func >= FUNC_W'(L1_DIRECT_MAX + 1)) && (pin0_func < FUNC_W'(L2_BASE))));
endmodule

bind pin_mux_ctrl pin_mux_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_rvalid_o(bus_rvalid_o), .key_hit(key_hit), .bank_unlocked(bank_unlocked),
  .pin0_func(pin_func_o[6:0]), .pin0_pull(pin_pull_o[1:0]),
  .pin0_drive(pin_drive_o[1:0]),
  .mdio0_sel_o(mdio0_sel_o), .mdio1_sel_o(mdio1_sel_o)
);

// File: tb/pin_mux_ctrl_tb.sv
module pin_mux_ctrl_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NP   = 170;
  localparam logic [31:0] BASE = 32'h4006_6000;
  localparam logic [31:0] B1   = BASE + 32'h1000;
  localparam logic [31:0] P0   = BASE + 32'h400;
  localparam logic [31:0] P1   = B1 + 32'h400;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rvalid;
  logic [NP*7-1:0] pin_func;
  logic [NP*2-1:0] pin_pull, pin_drive;
  logic [2:0] mdio0, mdio1;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_mux_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .pin_func_o(pin_func), .pin_pull_o(pin_pull),
    .pin_drive_o(pin_drive), .mdio0_sel_o(mdio0), .mdio1_sel_o(mdio1)
  );

  // Bench-side restatement of the function resolution rule.
  function automatic int model_func(int l1, int l2);
    if (l1 == 15) return 16 + l2;
    if (l1 >= 10) return 0;
    return l1;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_pin(input int p, input int f, input int pl, input int dr, input string tag);
    check(32'(pin_func[p*7 +: 7]), 32'(f), {tag, " func"});
    check(32'(pin_pull[p*2 +: 2]), 32'(pl), {tag, " pull"});
    check(32'(pin_drive[p*2 +: 2]), 32'(dr), {tag, " drive"});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  // Driver: push the expected word, then issue the read.
  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
  endtask

  // Monitor: compare each returned word with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(bus_rdata, 32'hDEAD_BEEF, "R9 unexpected read data");
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check_pin(5, 0, 0, 2, "R1 reset pin5");
    check(32'(mdio0), 0, "R1 reset mdio0");
    check(32'(mdio1), 0, "R1 reset mdio1");
    rd(P0, P0, "R1 bank0 locked");
    rd(P1, P1, "R1 bank1 locked");
    rd(BASE + 32'd12, 32'h800, "R1 reset word pin3");
    rd(B1 + 32'd12, 0, "R1 reset l2 pin3");

    // R4 locked writes dropped
    wr(BASE + 32'd12, 32'h0000_0D07);
    check_pin(3, 0, 0, 2, "R4 locked pin3");
    rd(BASE + 32'd12, 32'h800, "R4 locked readback");

    // R3 wrong keys
    wr(P0, 32'h1);
    wr(P0, P1 | 32'h1);
    rd(P0, P0, "R3 wrong key keeps lock");

    // R2 unlock bank0 only, then a write on the very next cycle
    wr(P0, P0 | 32'h1);
    wr(BASE + 32'd12, 32'h0000_0D07);
    rd(P0, P0 | 32'h1, "R2 bank0 unlocked");
    rd(P1, P1, "R2 bank1 still locked");
    check_pin(3, 7, 1, 3, "R5 pin3 fields");
    rd(BASE + 32'd12, 32'h0000_0D07, "R5 pin3 readback");

    // R5 upper junk bits dropped
    wr(BASE + 32'd16, 32'hFFFF_FB09);
    rd(BASE + 32'd16, 32'h0000_0B09, "R5 pin4 masked readback");
    check_pin(4, 9, 3, 2, "R5 pin4 fields");

    // R6 gap codes and hand-off
    wr(BASE + 32'd16, 32'h0000_0B0C);
    check_pin(4, model_func(12, 0), 3, 2, "R6 code 12 is hiz");
    wr(BASE + 32'd16, 32'h0000_0B0F);
    check_pin(4, model_func(15, 0), 3, 2, "R6 handoff l2=0");
    wr(B1 + 32'd16, 32'd61);
    check(32'(pin_func[4*7 +: 7]), 32'(model_func(15, 0)), "R4 bank1 locked l2");

    // R2 unlock bank1; R7 extended numbers
    wr(P1, P1 | 32'h1);
    wr(B1 + 32'd16, 32'hFFFF_FFFD);
    check(32'(pin_func[4*7 +: 7]), 32'(model_func(15, 61)), "R6 handoff l2=61");
    rd(B1 + 32'd16, 32'd61, "R7 l2 masked readback");
    wr(B1 + 32'd20, 32'd30);
    check(32'(pin_func[5*7 +: 7]), 32'(model_func(0, 30)), "R6 l2 ignored when l1=0");
    rd(B1 + 32'd20, 32'd30, "R7 pin5 l2 readback");

    // R5 last pin
    wr(BASE + 32'(4*(NP-1)), 32'h0000_000F);
    wr(B1 + 32'(4*(NP-1)), 32'd1);
    check_pin(NP-1, model_func(15, 1), 0, 0, "R5 last pin");

    // R8 MDIO selects
    wr(B1 + 32'h404, 32'd5);
    wr(B1 + 32'h408, 32'hFF);
    check(32'(mdio0), 5, "R8 mdio0");
    check(32'(mdio1), 7, "R8 mdio1");
    rd(B1 + 32'h404, 5, "R8 mdio0 readback");
    rd(B1 + 32'h408, 7, "R8 mdio1 readback");

    // R2 relock both; R4 dropped writes
    wr(P1, P1);
    wr(B1 + 32'h404, 32'd2);
    check(32'(mdio0), 5, "R4 mdio0 locked");
    rd(B1 + 32'h404, 5, "R4 mdio0 locked readback");
    rd(P1, P1, "R2 bank1 relocked");
    wr(P0, P0);
    wr(BASE + 32'd12, 32'h0000_0001);
    check_pin(3, 7, 1, 3, "R4 pin3 after relock");
    rd(BASE + 32'd12, 32'h0000_0D07, "R4 pin3 relock readback");

    // R9 unmapped reads
    rd(BASE + 32'(4*NP), 0, "R9 past last pin");
    rd(BASE + 32'h404, 0, "R9 bank0 has no mdio");
    rd(32'h1000_000C, 0, "R9 outside window");

    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 0, "R9 all reads answered");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule